// File: doc/BRIEF.md
# Regulator Standby Wake-Up Sequencer

This block decides what happens to the on-chip regulator and the flash supply when the processor enters Sleep, and when the core may resume after a wake event. When Sleep is entered, the block does one of two things, depending on a control bit sampled at that moment. It either drops the regulator into a low-power standby and switches flash power off, or it keeps flash powered through the whole Sleep.

After a wake event from standby, flash power is restored at once. Core-ready is then held low for a delay counted in microsecond tick pulses. A two-bit select field picks a slow legacy delay or a fast delay. A wake from the flash-powered Sleep needs no delay. A new sleep request that arrives during the delay aborts the wake and goes back into standby.

Top module: `reg_standby_seq`

## Requirements
- R1: After reset the block is in normal run: flash_pwr_o=1, standby_o=0, core_ready_o=1.
- R2: A sleep_i pulse in run with keep_flash_i=0 gives standby_o=1, flash_pwr_o=0, core_ready_o=0 from the next cycle on.
- R3: A sleep_i pulse in run with keep_flash_i=1 keeps flash_pwr_o=1 and standby_o=0, with core_ready_o=0. A later wake_i pulse sets core_ready_o=1 in the next cycle, with no tick needed.
- R4: A wake_i pulse in standby clears standby_o and sets flash_pwr_o in the next cycle. core_ready_o stays 0 while the delay counts.
- R5: With wake_sel_i=2'b00 at the wake event, core_ready_o rises in the cycle after the 190th us_tick_i pulse seen after the wake cycle.
- R6: With wake_sel_i=2'b01 at the wake event, the delay is 10 tick pulses.
- R7: The codes wake_sel_i=2'b10 and 2'b11 give the same 190-tick delay as 2'b00.
- R8: A sleep_i pulse during the delay returns the block to standby in the next cycle. This takes priority over a tick that would complete the count.
- R9: sleep_i has no effect while in Sleep or standby, and wake_i has no effect in run.
- R10: wake_sel_i is captured at the wake event. Changes to it during the delay do not alter that delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Sleep-entry strobe |
| wake_i | input | 1 | Wake-event strobe |
| keep_flash_i | input | 1 | 1 keeps flash powered in Sleep (standby disabled) |
| wake_sel_i | input | 2 | Wake delay select: 01 fast, other codes legacy |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| flash_pwr_o | output | 1 | Flash power enable |
| standby_o | output | 1 | Regulator is in standby |
| core_ready_o | output | 1 | Core may run |

## Verification
Every output is registered. A strobe or tick at one clock edge therefore shows up at the ports one cycle later. A wake from standby sets flash_pwr_o and clears standby_o one cycle after wake_i. core_ready_o rises one cycle after the tick that completes the count. An abort becomes visible one cycle after sleep_i. The bench drives inputs on the falling edge and updates its reference model at the rising edge. It compares all three outputs on the next falling edge, so each expectation is checked in exactly the cycle it falls due. Directed checks count ticks up to one before the full delay and then up to the full delay, to pin down the boundary.

// File: rtl/regsb_pkg.sv
package regsb_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_SLEEP_PWR = 2'd1,
    ST_STANDBY   = 2'd2,
    ST_WAKE      = 2'd3
  } regsb_state_e;

  localparam logic [1:0] WSEL_FAST = 2'b01;
endpackage

// File: rtl/regsb_delay_sel.sv
module regsb_delay_sel #(
  parameter int LEGACY_US = 190,
  parameter int FAST_US   = 10,
  parameter int CNT_W     = 8
) (
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] dly_o
);
  import regsb_pkg::*;

  // reserved codes fall back to legacy
  always_comb begin
    if (sel_i == WSEL_FAST) dly_o = CNT_W'(FAST_US);
    else                    dly_o = CNT_W'(LEGACY_US);
  end
endmodule

// File: rtl/regsb_wake_cnt.sv
module regsb_wake_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             en_i,
  input  logic             tick_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (load_i)                        cnt_q <= load_val_i;
    else if (en_i && tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = en_i && tick_i && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/reg_standby_seq.sv
module reg_standby_seq #(
  parameter int LEGACY_US = 190,
  parameter int FAST_US   = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic       wake_i,
  input  logic       keep_flash_i,
  input  logic [1:0] wake_sel_i,
  input  logic       us_tick_i,
  output logic       flash_pwr_o,
  output logic       standby_o,
  output logic       core_ready_o
);
  import regsb_pkg::*;

  localparam int MAX_US = (LEGACY_US > FAST_US) ? LEGACY_US : FAST_US;
  localparam int CNT_W  = $clog2(MAX_US + 1);

  regsb_state_e     st_q, st_d;
  logic [CNT_W-1:0] dly;
  logic             cnt_load, cnt_done;

  regsb_delay_sel #(
    .LEGACY_US(LEGACY_US),
    .FAST_US  (FAST_US),
    .CNT_W    (CNT_W)
  ) u_dsel (
    .sel_i(wake_sel_i),
    .dly_o(dly)
  );

  assign cnt_load = (st_q == ST_STANDBY) && wake_i;

  regsb_wake_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cnt_load),
    .load_val_i(dly),
    .en_i      (st_q == ST_WAKE),
    .tick_i    (us_tick_i),
    .done_o    (cnt_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:       if (sleep_i) st_d = keep_flash_i ? ST_SLEEP_PWR : ST_STANDBY;
      ST_SLEEP_PWR: if (wake_i)  st_d = ST_RUN;
      ST_STANDBY:   if (wake_i)  st_d = ST_WAKE;
      ST_WAKE: begin
        // abort wins over completion
        if (sleep_i)       st_d = ST_STANDBY;
        else if (cnt_done) st_d = ST_RUN;
      end
      default:             st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_RUN;
      flash_pwr_o  <= 1'b1;
      standby_o    <= 1'b0;
      core_ready_o <= 1'b1;
    end else begin
      st_q         <= st_d;
      flash_pwr_o  <= (st_d != ST_STANDBY);
      standby_o    <= (st_d == ST_STANDBY);
      core_ready_o <= (st_d == ST_RUN);
    end
  end
endmodule

// File: rtl/reg_standby_seq_chk.sv
module reg_standby_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_i,
  input logic       wake_i,
  input logic       keep_flash_i,
  input logic [1:0] wake_sel_i,
  input logic       us_tick_i,
  input logic       flash_pwr_o,
  input logic       standby_o,
  input logic       core_ready_o
);
  a_r2_sleep_to_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_ready_o && sleep_i && !keep_flash_i |=> standby_o && !flash_pwr_o && !core_ready_o);

  a_r2_standby_no_flash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !flash_pwr_o && !core_ready_o);

  a_r3_sleep_keeps_flash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_ready_o && sleep_i && keep_flash_i |=> flash_pwr_o && !standby_o && !core_ready_o);

  a_r4_wake_restores_flash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o && wake_i |=> !standby_o && flash_pwr_o && !core_ready_o);

  a_r5_ready_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_ready_o) |-> $past(us_tick_i) || $past(wake_i));

  a_r9_run_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_ready_o && !sleep_i |=> core_ready_o);

  a_r9_standby_ignores_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o && !wake_i |=> standby_o);
endmodule

bind reg_standby_seq reg_standby_seq_chk u_chk (.*);

// File: tb/reg_standby_seq_tb.sv
module reg_standby_seq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sleep_i = 1'b0, wake_i = 1'b0, keep_flash_i = 1'b0, us_tick_i = 1'b0;
  logic [1:0] wake_sel_i = 2'b00;
  logic       flash_pwr_o, standby_o, core_ready_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef enum {M_RUN, M_SLP, M_STB, M_WAK} m_e;
  m_e m_st = M_RUN;
  int m_rem = 0;

  always #4 clk_i = ~clk_i;

  reg_standby_seq u_dut (.*);

  function automatic int exp_delay(logic [1:0] s);
    return (s == 2'b01) ? 10 : 190;
  endfunction

  function automatic void model_step(logic s, logic w, logic t, logic k, logic [1:0] sel);
    case (m_st)
      M_RUN: if (s) m_st = k ? M_SLP : M_STB;
      M_SLP: if (w) m_st = M_RUN;
      M_STB: if (w) begin m_st = M_WAK; m_rem = exp_delay(sel); end
      M_WAK: begin
        if (s) m_st = M_STB;
        else if (t) begin
          m_rem--;
          if (m_rem == 0) m_st = M_RUN;
        end
      end
    endcase
  endfunction

  task automatic chk(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_model();
    chk("R1/R2/R4", flash_pwr_o, m_st != M_STB, "flash_pwr_o");
    chk("R2/R4", standby_o, m_st == M_STB, "standby_o");
    chk("R5/R6/R8", core_ready_o, m_st == M_RUN, "core_ready_o");
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(logic s, logic w, logic t);
    sleep_i = s; wake_i = w; us_tick_i = t;
    @(posedge clk_i);
    model_step(s, w, t, keep_flash_i, wake_sel_i);
    @(negedge clk_i);
    sleep_i = 0; wake_i = 0; us_tick_i = 0;
    chk_model();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(0, 0, 1);
  endtask

  task automatic wake_delay_case(logic [1:0] sel, int n, string req);
    keep_flash_i = 0;
    step(1, 0, 0);
    wake_sel_i = sel;
    step(0, 1, 0);
    chk("R4", flash_pwr_o, 1'b1, "flash after wake");
    ticks(n - 1);
    chk(req, core_ready_o, 1'b0, "ready one tick early");
    step(0, 0, 1);
    chk(req, core_ready_o, 1'b1, "ready at full count");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", flash_pwr_o, 1'b1, "flash reset");
    chk("R1", standby_o, 1'b0, "standby reset");
    chk("R1", core_ready_o, 1'b1, "ready reset");

    // R9 wake in run ignored
    step(0, 1, 1);
    chk("R9", core_ready_o, 1'b1, "wake in run");

    // R2 entry
    keep_flash_i = 0;
    step(1, 0, 0);
    chk("R2", standby_o, 1'b1, "standby set");
    chk("R2", flash_pwr_o, 1'b0, "flash off");
    // R9 sleep in standby ignored
    step(1, 0, 1);
    chk("R9", standby_o, 1'b1, "sleep in standby");
    wake_sel_i = 2'b01;
    step(0, 1, 0);
    chk("R4", standby_o, 1'b0, "standby cleared");
    chk("R4", core_ready_o, 1'b0, "ready low while counting");
    ticks(9);
    chk("R6", core_ready_o, 1'b0, "fast 9 ticks");
    step(0, 0, 1);
    chk("R6", core_ready_o, 1'b1, "fast 10 ticks");

    wake_delay_case(2'b00, 190, "R5");
    wake_delay_case(2'b10, 190, "R7");
    wake_delay_case(2'b11, 190, "R7");

    // R10 sel change during count ignored
    step(1, 0, 0);
    wake_sel_i = 2'b01;
    step(0, 1, 0);
    wake_sel_i = 2'b00;
    ticks(10);
    chk("R10", core_ready_o, 1'b1, "captured fast delay");

    // R8 abort on completing tick
    step(1, 0, 0);
    wake_sel_i = 2'b01;
    step(0, 1, 0);
    ticks(9);
    step(1, 0, 1);
    chk("R8", standby_o, 1'b1, "abort to standby");
    chk("R8", core_ready_o, 1'b0, "abort ready low");
    step(0, 1, 0);
    ticks(10);
    chk("R8", core_ready_o, 1'b1, "rewake after abort");

    // R3 flash kept, no delay
    keep_flash_i = 1;
    step(1, 0, 0);
    chk("R3", flash_pwr_o, 1'b1, "flash kept");
    chk("R3", standby_o, 1'b0, "no standby");
    chk("R3", core_ready_o, 1'b0, "ready low in sleep");
    step(1, 0, 0);
    chk("R9", core_ready_o, 1'b0, "sleep in sleep");
    step(0, 1, 0);
    chk("R3", core_ready_o, 1'b1, "instant wake");

    // random phase
    for (int i = 0; i < 30000; i++) begin
      if ($urandom_range(0, 63) == 0) keep_flash_i = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 15) == 0) wake_sel_i = 2'($urandom_range(0, 3));
      step($urandom_range(0, 299) == 0, $urandom_range(0, 39) == 0,
           $urandom_range(0, 2) == 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule